// File: doc/BRIEF.md
# Peripheral Channel Selector and Word Transfer Path

This block attaches one of sixteen peripheral channels to the CPU's 12-bit data and address buses. A 4-bit selector register names the attached channel. Software loads it through a strobe during normal running. The console loads it through a second strobe, which takes effect only while the machine is halted. Every transfer moves one word between the attached channel and main memory (4096 words of 12 bits). The memory address always comes from a pointer register placed on the address bus. No channel ever exchanges data with a CPU register.

The CPU starts every transfer with a single-cycle strobe. The input strobe writes the word offered by the attached channel into memory at the pointer address. The output strobe hands the memory word at the pointer address to the attached channel. A two-state machine controls the channel bus drivers. In state DETACHED, all drivers are off. In state ATTACHED, only the selected channel's driver is on. Reset leaves the machine in DETACHED with channel 0 selected. The transition DETACHED→ATTACHED is taken on any transfer strobe. The transition ATTACHED→DETACHED (or staying in DETACHED) is taken on any accepted selector load, and a selector load wins over a strobe in the same cycle.

Peripherals cannot start transfers. They can only raise request lines, which are merged into one CPU interrupt together with the number of the lowest pending channel.

Top module: `io_chan_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the selected channel is 0, all channel bus drivers are off, and no memory or channel strobe is active.
- R2: A software select strobe loads the selector with its 4-bit value at the next clock edge, whether the machine is halted or running.
- R3: A console select strobe is ignored while the machine is running. While the machine is halted, it loads the selector at the next edge and takes priority over a software strobe in the same cycle.
- R4: An input strobe, in the same cycle, asserts the memory write, drives the memory address with the pointer, drives the memory write data with the selected channel's word (channel n occupies bits 12n+11..12n of the channel data input), and asserts the read acknowledge of only the selected channel.
- R5: An output strobe alone, in the same cycle, asserts the memory read, drives the memory address with the pointer, places the memory read data on the channel write bus, and asserts the write strobe of only the selected channel.
- R6: When the input and output strobes arrive together, the input transfer is performed and the output strobe has no effect: there is no memory read and no channel write strobe.
- R7: At most one channel bus driver is on at any time. In state ATTACHED, the driver that is on is bit n of the driver enable, where n is the current selection.
- R8: The machine enters ATTACHED after a cycle that has a transfer strobe and no accepted selector load. It enters DETACHED, with all drivers off, after any cycle with an accepted selector load, including one that coincides with a strobe. A transfer in such a cycle uses the previously selected channel.
- R9: Without a transfer strobe, the memory write, memory read, and all channel read and write strobes stay low.
- R10: The CPU interrupt is the OR of the 16 channel request lines. The interrupt code gives the lowest-numbered channel whose request is high, and is 0 when none is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halted | input | 1 | Machine is halted |
| sw_sel_we | input | 1 | Software select strobe |
| sw_sel_val | input | 4 | Software select value |
| con_sel_we | input | 1 | Console select strobe |
| con_sel_val | input | 4 | Console switch value |
| in_stb | input | 1 | Channel-to-memory transfer strobe |
| out_stb | input | 1 | Memory-to-channel transfer strobe |
| ptr_addr | input | 12 | Pointer register on the address bus |
| mem_rdata | input | 12 | Memory read data |
| ch_rdata | input | 192 | Words offered by all channels, 12 bits each |
| ch_irq | input | 16 | Channel interrupt requests |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write |
| mem_re | output | 1 | Memory read |
| ch_wdata | output | 12 | Word presented to channels |
| ch_wr | output | 16 | Per-channel write strobe |
| ch_rd | output | 16 | Per-channel read acknowledge |
| ch_drv_en | output | 16 | Per-channel bus driver enable |
| sel_cur | output | 4 | Current channel selection |
| cpu_irq | output | 1 | Merged interrupt request |
| irq_code | output | 4 | Lowest pending channel number |

## Verification
The functions that can collide are a selector load and a transfer strobe in the same cycle. Random stimulus provokes this often by drawing select strobes, console strobes, halt and both transfer strobes independently, and directed cycles force it with a selector value different from the current one. The bench model judges the result: the transfer in that cycle must name the old channel, and the next cycle must show the new selection with all drivers off. Coinciding console and software loads while halted are judged the same way.

// File: rtl/io_chan_pkg.sv
package io_chan_pkg;
    typedef enum logic {
        ST_DETACHED = 1'b0,
        ST_ATTACHED = 1'b1
    } att_state_t;

    typedef enum logic [1:0] {
        XF_NONE = 2'd0,
        XF_IN   = 2'd1,
        XF_OUT  = 2'd2
    } xfer_kind_t;
endpackage

// File: rtl/io_sel_reg.sv
module io_sel_reg #(
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halted,
    input  logic            sw_we,
    input  logic [SELW-1:0] sw_val,
    input  logic            con_we,
    input  logic [SELW-1:0] con_val,
    output logic [SELW-1:0] sel_q,
    output logic            sel_load
);
    logic            con_ok;
    logic [SELW-1:0] sel_d;

    always_comb begin
        con_ok   = con_we && halted;
        sel_load = con_ok || sw_we;
        sel_d    = sel_q;
        if (con_ok)
            sel_d = con_val;
        else if (sw_we)
            sel_d = sw_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else
            sel_q <= sel_d;
    end

    AST_CON_IGNORED_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (con_we && !halted && !sw_we) |=> $stable(sel_q)); // R3
    AST_SW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !(con_we && halted)) |=> (sel_q == $past(sw_val))); // R2
    AST_CON_LOADS_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (con_we && halted) |=> (sel_q == $past(con_val))); // R3
endmodule

// File: rtl/io_xfer_path.sv
module io_xfer_path
    import io_chan_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int DW   = 12,
    parameter int AW   = 12,
    parameter int SELW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SELW-1:0]   sel,
    input  logic              in_stb,
    input  logic              out_stb,
    input  logic [AW-1:0]     ptr_addr,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [NCH*DW-1:0] ch_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DW-1:0]     ch_wdata,
    output logic [NCH-1:0]    ch_wr,
    output logic [NCH-1:0]    ch_rd
);
    xfer_kind_t     kind;
    logic [NCH-1:0] sel_hit;

    always_comb begin
        if (in_stb)
            kind = XF_IN;
        else if (out_stb)
            kind = XF_OUT;
        else
            kind = XF_NONE;
    end

    always_comb begin
        mem_addr  = ptr_addr;
        mem_wdata = ch_rdata[sel*DW +: DW];
        ch_wdata  = mem_rdata;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        unique case (kind)
            XF_IN:   mem_we = 1'b1;
            XF_OUT:  mem_re = 1'b1;
            XF_NONE: ;
            default: ;
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign sel_hit[g] = (sel == SELW'(g));
        assign ch_rd[g]   = sel_hit[g] && (kind == XF_IN);
        assign ch_wr[g]   = sel_hit[g] && (kind == XF_OUT);
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R6
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stb && !out_stb) |-> (!mem_we && !mem_re && ch_wr == '0 && ch_rd == '0)); // R9
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rd | ch_wr)); // R4
endmodule

// File: rtl/io_irq_merge.sv
module io_irq_merge #(
    parameter int NCH  = 16,
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  ch_irq,
    output logic            cpu_irq,
    output logic [SELW-1:0] irq_code
);
    always_comb begin
        cpu_irq  = |ch_irq;
        irq_code = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ch_irq[i])
                irq_code = SELW'(i);
        end
    end

    AST_IRQ_CODE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ch_irq[irq_code]); // R10
    AST_IRQ_CODE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_irq != '0) |-> ((ch_irq & ((NCH'(1) << irq_code) - NCH'(1))) == '0)); // R10
endmodule

// File: rtl/io_chan_sel.sv
module io_chan_sel
    import io_chan_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int DW   = 12,
    parameter int AW   = 12,
    parameter int SELW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              sw_sel_we,
    input  logic [SELW-1:0]   sw_sel_val,
    input  logic              con_sel_we,
    input  logic [SELW-1:0]   con_sel_val,
    input  logic              in_stb,
    input  logic              out_stb,
    input  logic [AW-1:0]     ptr_addr,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [NCH*DW-1:0] ch_rdata,
    input  logic [NCH-1:0]    ch_irq,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DW-1:0]     ch_wdata,
    output logic [NCH-1:0]    ch_wr,
    output logic [NCH-1:0]    ch_rd,
    output logic [NCH-1:0]    ch_drv_en,
    output logic [SELW-1:0]   sel_cur,
    output logic              cpu_irq,
    output logic [SELW-1:0]   irq_code
);
    att_state_t state_q, state_d;
    logic       sel_load;
    logic       any_stb;

    io_sel_reg #(.SELW(SELW)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted   (halted),
        .sw_we    (sw_sel_we),
        .sw_val   (sw_sel_val),
        .con_we   (con_sel_we),
        .con_val  (con_sel_val),
        .sel_q    (sel_cur),
        .sel_load (sel_load)
    );

    io_xfer_path #(.NCH(NCH), .DW(DW), .AW(AW), .SELW(SELW)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_cur),
        .in_stb    (in_stb),
        .out_stb   (out_stb),
        .ptr_addr  (ptr_addr),
        .mem_rdata (mem_rdata),
        .ch_rdata  (ch_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .ch_wdata  (ch_wdata),
        .ch_wr     (ch_wr),
        .ch_rd     (ch_rd)
    );

    io_irq_merge #(.NCH(NCH), .SELW(SELW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_irq   (ch_irq),
        .cpu_irq  (cpu_irq),
        .irq_code (irq_code)
    );

    assign any_stb = in_stb || out_stb;

    // Next-state: a selector load always detaches; a strobe attaches.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DETACHED: if (!sel_load && any_stb) state_d = ST_ATTACHED;
            ST_ATTACHED: if (sel_load)             state_d = ST_DETACHED;
            default:     state_d = ST_DETACHED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_DETACHED;
        else
            state_q <= state_d;
    end

    // Outputs: driver enable follows the state and the current selection.
    always_comb begin
        ch_drv_en = '0;
        unique case (state_q)
            ST_ATTACHED: ch_drv_en = NCH'(1) << sel_cur;
            ST_DETACHED: ch_drv_en = '0;
            default:     ch_drv_en = '0;
        endcase
    end

    AST_DRV_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_drv_en)); // R7
    AST_RESELECT_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
        sel_load |=> (ch_drv_en == '0)); // R8
    AST_STROBE_ATTACH: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && !sel_load) |=> (ch_drv_en != '0)); // R8
endmodule

// File: tb/io_chan_sel_test.sv
module io_chan_sel_test;
    localparam int NCH = 16;
    localparam int DW  = 12;
    localparam int AW  = 12;
    localparam int SW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halted = 1'b0, sw_sel_we = 1'b0, con_sel_we = 1'b0;
    logic [SW-1:0] sw_sel_val = '0, con_sel_val = '0;
    logic in_stb = 1'b0, out_stb = 1'b0;
    logic [AW-1:0] ptr_addr = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic [NCH*DW-1:0] ch_rdata = '0;
    logic [NCH-1:0] ch_irq = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, ch_wdata;
    logic mem_we, mem_re, cpu_irq;
    logic [NCH-1:0] ch_wr, ch_rd, ch_drv_en;
    logic [SW-1:0] sel_cur, irq_code;

    int n_tests = 0;
    int n_fail  = 0;
    logic [SW-1:0] m_sel = '0;
    logic          m_att = 1'b0;
    logic          done  = 1'b0;

    always #2 clk = ~clk;

    io_chan_sel uut (
        .clk(clk), .rst_n(rst_n), .halted(halted),
        .sw_sel_we(sw_sel_we), .sw_sel_val(sw_sel_val),
        .con_sel_we(con_sel_we), .con_sel_val(con_sel_val),
        .in_stb(in_stb), .out_stb(out_stb), .ptr_addr(ptr_addr),
        .mem_rdata(mem_rdata), .ch_rdata(ch_rdata), .ch_irq(ch_irq),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .ch_wdata(ch_wdata), .ch_wr(ch_wr), .ch_rd(ch_rd),
        .ch_drv_en(ch_drv_en), .sel_cur(sel_cur), .cpu_irq(cpu_irq),
        .irq_code(irq_code)
    );

    function automatic logic [SW-1:0] low_code(input logic [NCH-1:0] r);
        logic [SW-1:0] c = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (r[i]) c = SW'(i);
        return c;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic h, input logic swe, input logic [SW-1:0] swv,
                        input logic cwe, input logic [SW-1:0] cwv,
                        input logic ins, input logic outs,
                        input logic [AW-1:0] ptr, input logic [DW-1:0] md,
                        input logic [NCH-1:0] irq);
        logic [NCH-1:0] one;
        logic [DW-1:0]  word;
        @(negedge clk);
        halted = h; sw_sel_we = swe; sw_sel_val = swv;
        con_sel_we = cwe; con_sel_val = cwv;
        in_stb = ins; out_stb = outs; ptr_addr = ptr; mem_rdata = md; ch_irq = irq;
        for (int i = 0; i < NCH; i++) ch_rdata[i*DW +: DW] = DW'($urandom);
        #1;
        one  = NCH'(1) << m_sel;
        word = ch_rdata[m_sel*DW +: DW];
        chk("R2 R3", "sel_cur", 32'(sel_cur), 32'(m_sel));
        chk("R7 R8", "ch_drv_en", 32'(ch_drv_en), m_att ? 32'(one) : 32'd0);
        chk("R10", "cpu_irq", 32'(cpu_irq), 32'(|irq));
        chk("R10", "irq_code", 32'(irq_code), 32'(low_code(irq)));
        if (ins) begin
            chk("R4", "mem_we", 32'(mem_we), 32'd1);
            chk("R4", "mem_addr", 32'(mem_addr), 32'(ptr));
            chk("R4", "mem_wdata", 32'(mem_wdata), 32'(word));
            chk("R4", "ch_rd", 32'(ch_rd), 32'(one));
            chk(outs ? "R6" : "R4", "mem_re", 32'(mem_re), 32'd0);
            chk(outs ? "R6" : "R4", "ch_wr", 32'(ch_wr), 32'd0);
        end else if (outs) begin
            chk("R5", "mem_re", 32'(mem_re), 32'd1);
            chk("R5", "mem_we", 32'(mem_we), 32'd0);
            chk("R5", "mem_addr", 32'(mem_addr), 32'(ptr));
            chk("R5", "ch_wdata", 32'(ch_wdata), 32'(md));
            chk("R5", "ch_wr", 32'(ch_wr), 32'(one));
            chk("R5", "ch_rd", 32'(ch_rd), 32'd0);
        end else begin
            chk("R9", "strobes", {mem_we, mem_re, ch_wr, ch_rd}, 32'd0);
        end
        // model update for the coming edge
        if (cwe && h) begin
            m_sel = cwv; m_att = 1'b0;
        end else if (swe) begin
            m_sel = swv; m_att = 1'b0;
        end else if (ins || outs) begin
            m_att = 1'b1;
        end
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset sel", 32'(sel_cur), 32'd0);
        chk("R1", "reset drv", 32'(ch_drv_en), 32'd0);
        chk("R1", "reset strobes", {mem_we, mem_re, ch_wr, ch_rd}, 32'd0);
        rst_n = 1'b1;
        // first cycle after reset: idle
        tick(0, 0, 0, 0, 0, 0, 0, 12'h000, 12'h000, 16'h0000);
        // R3: console while running ignored
        tick(0, 0, 0, 1, 4'd9, 0, 0, 12'h010, 12'h000, 16'h8000);
        // R2: software load running, then a strobe attaches
        tick(0, 1, 4'd5, 0, 0, 0, 0, 12'h020, 12'h000, 16'h0000);
        tick(0, 0, 0, 0, 0, 1, 0, 12'hFFF, 12'hABC, 16'h0001);
        // R8: reselect coinciding with a strobe uses old channel
        tick(0, 1, 4'd15, 0, 0, 0, 1, 12'h123, 12'h456, 16'h0000);
        tick(0, 0, 0, 0, 0, 0, 0, 12'h000, 12'h000, 16'hFFFF);
        // R6: both strobes
        tick(0, 0, 0, 0, 0, 1, 1, 12'h7FF, 12'h555, 16'h0000);
        // R3: halted, console and software together: console wins
        tick(1, 1, 4'd2, 1, 4'd12, 0, 0, 12'h000, 12'h000, 16'h0000);
        tick(1, 0, 0, 0, 0, 0, 1, 12'h800, 12'hFFF, 16'h0000);
        tick(1, 0, 0, 0, 0, 0, 0, 12'h000, 12'h000, 16'h0000);
        for (int n = 0; n < 4000; n++) begin
            tick(($urandom % 3) == 0, ($urandom % 6) == 0, SW'($urandom),
                 ($urandom % 5) == 0, SW'($urandom),
                 ($urandom % 3) == 0, ($urandom % 3) == 0,
                 AW'($urandom), DW'($urandom),
                 (($urandom % 4) == 0) ? NCH'(0) : NCH'($urandom) & NCH'($urandom));
        end
        tick(0, 0, 0, 0, 0, 0, 0, 12'h000, 12'h000, 16'h0000);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule